// File: doc/BRIEF.md
# Latched One-Hot Select Decoder

This block turns a small binary code into a one-hot select bus of `2**CODE_W` lines. A holding register sits in front of the decoder. While `strobe` is high the incoming code goes straight to the decoder. When `strobe` drops, the code from the last clock edge with `strobe` high stays held. Later changes on `code` then have no effect until `strobe` rises again.

An `inhibit` input drives every select line to its idle level. It does this without touching the held code. When `inhibit` is released, the decode of the held code appears again. A build-time parameter picks the polarity of the bus. With `ACTIVE_LOW = 0` the chosen line is 1 and all others are 0. With `ACTIVE_LOW = 1` the bus is the bitwise inverse of that. Everything is sampled on a system clock, and the select bus comes from a register.

Top module: `code_select_decoder`

## Requirements
- R1: A clock edge with `rst` high clears the held code to 0 and drives the select bus to its idle level (all 0 when `ACTIVE_LOW = 0`, all 1 when `ACTIVE_LOW = 1`) on the next output update.
- R2: When `strobe` is high at a clock edge, the select bus after that edge shows the decode of the `code` value sampled at that edge.
- R3: When `strobe` is low at a clock edge, the decode uses the code sampled at the most recent earlier edge with `strobe` high (0 if none since reset). Changes on `code` while `strobe` is low do not change `sel`.
- R4: Code value n, read as unsigned binary with `code[CODE_W-1]` as the most significant bit, selects line `sel[n]`. Code 0 selects `sel[0]` and the all-ones code selects the top line.
- R5: With `ACTIVE_LOW = 0` the selected line is 1 and all other lines are 0.
- R6: With `ACTIVE_LOW = 1` the select bus is the bitwise inverse of the active-high bus for the same input history.
- R7: When `inhibit` is high at a clock edge, every line is at its idle level after that edge, whatever the code or strobe.
- R8: `inhibit` does not alter the held code. When `inhibit` is released with `strobe` low, the decode of the code held before the inhibit appears.
- R9: Outside reset and with `inhibit` low at the previous edge, exactly one line is active.
- R10: The select bus is registered. It changes only at a clock edge and reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | High: code passes through; low: held code is used |
| inhibit | input | 1 | High: all select lines idle |
| code | input | CODE_W | Binary select code |
| sel | output | 2**CODE_W | Registered one-hot select bus, polarity set by ACTIVE_LOW |

## Verification
First, all sixteen codes are applied with `strobe` high. This shows that each code reaches its own line with one cycle of delay, and that the bit weighting is not reversed. Next, `code` changes while `strobe` is low. This shows that the value is held and not passed through, and that the held value is the one from the last strobed edge and not from an older one. `inhibit` is then pulsed both with `strobe` low and with `strobe` high. This shows that it only blanks the outputs and does not load or clear the held code. Two copies of the block run side by side, one per polarity, and each is compared on every clock with a behavioural model.

// File: rtl/seldec_pkg.sv
package seldec_pkg;
  // map an internal "line chosen" flag onto the pin level for a given polarity
  function automatic logic pin_level(input logic chosen, input bit active_low);
    return chosen ^ active_low;
  endfunction
endpackage

// File: rtl/code_hold.sv
module code_hold #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_eff
);
  logic [CODE_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (strobe) held_q <= code_in;
  end

  // transparent while strobe is high, frozen otherwise
  assign code_eff = strobe ? code_in : held_q;
endmodule

// File: rtl/onehot_expand.sv
module onehot_expand #(
  parameter int CODE_W  = 4,
  parameter int NUM_OUT = 1 << CODE_W
) (
  input  logic [CODE_W-1:0]  code,
  output logic [NUM_OUT-1:0] hot
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    localparam logic [CODE_W-1:0] IDX = CODE_W'(i);
    assign hot[i] = (code == IDX);
  end
endmodule

// File: rtl/select_drive.sv
module select_drive
  import seldec_pkg::*;
#(
  parameter int NUM_OUT    = 16,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inhibit,
  input  logic [NUM_OUT-1:0] hot,
  output logic [NUM_OUT-1:0] sel_q
);
  localparam logic [NUM_OUT-1:0] IDLE = ACTIVE_LOW ? '1 : '0;

  logic [NUM_OUT-1:0] pin_d;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    assign pin_d[i] = pin_level(hot[i] & ~inhibit, ACTIVE_LOW);
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= IDLE;
    else     sel_q <= pin_d;
  end
endmodule

// File: rtl/code_select_decoder.sv
module code_select_decoder #(
  parameter int CODE_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int NUM_OUT   = 1 << CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic               inhibit,
  input  logic [CODE_W-1:0]  code,
  output logic [NUM_OUT-1:0] sel
);
  logic [CODE_W-1:0]  code_eff;
  logic [NUM_OUT-1:0] hot;

  code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .code_in  (code),
    .code_eff (code_eff)
  );

  onehot_expand #(.CODE_W(CODE_W), .NUM_OUT(NUM_OUT)) u_expand (
    .code (code_eff),
    .hot  (hot)
  );

  select_drive #(.NUM_OUT(NUM_OUT), .ACTIVE_LOW(ACTIVE_LOW)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .inhibit (inhibit),
    .hot     (hot),
    .sel_q   (sel)
  );
endmodule

// File: rtl/code_select_decoder_chk.sv
module code_select_decoder_chk #(
  parameter int CODE_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int NUM_OUT   = 1 << CODE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               strobe,
  input logic               inhibit,
  input logic [CODE_W-1:0]  code,
  input logic [NUM_OUT-1:0] sel
);
  logic [NUM_OUT-1:0] act;
  logic       seen_rst = 1'b0;
  logic [1:0] since    = 2'd0;

  assign act = ACTIVE_LOW ? ~sel : sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_rst <= 1'b1;
      since    <= 2'd0;
    end else if (since != 2'd3) begin
      since <= since + 2'd1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    seen_rst && $past(rst) |-> act == '0);

  assert_inhibit_idle_R7: assert property (@(posedge clk) disable iff (rst)
    seen_rst && since >= 2'd1 && $past(inhibit) |-> act == '0);

  assert_single_active_R9: assert property (@(posedge clk) disable iff (rst)
    seen_rst && since >= 2'd1 && !$past(inhibit) |-> $countones(act) == 1);

  // strobe low on two edges and no inhibit: output must not move (R3)
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    seen_rst && since >= 2'd2 && !$past(strobe) && !$past(strobe, 2)
    && !$past(inhibit) && !$past(inhibit, 2) |-> $stable(sel));
endmodule

bind code_select_decoder code_select_decoder_chk #(
  .CODE_W(CODE_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit), .code(code), .sel(sel)
);

// File: tb/code_select_decoder_bench.sv
`timescale 1ns/1ps
module code_select_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        strobe = 1'b0;
  logic        inhibit = 1'b0;
  logic [3:0]  code = 4'd0;
  logic [15:0] sel_hi, sel_lo;

  always #2.5 clk = ~clk;

  code_select_decoder #(.CODE_W(4), .ACTIVE_LOW(1'b0)) u_code_select_decoder (
    .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit), .code(code), .sel(sel_hi)
  );
  code_select_decoder #(.CODE_W(4), .ACTIVE_LOW(1'b1)) u_code_select_decoder_lo (
    .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit), .code(code), .sel(sel_lo)
  );

  int compared = 0;
  int mismatched = 0;
  bit live = 1'b0;
  bit finished = 1'b0;
  string tag = "R1";
  int held = 0;
  logic [15:0] exp_hi = 16'h0;

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int eff;
    if (rst) begin
      held   = 0;
      exp_hi = 16'h0;
      live   = 1'b1;
    end else begin
      eff    = strobe ? int'(code) : held;
      exp_hi = inhibit ? 16'h0 : (16'h1 << eff);
      if (strobe) held = int'(code);
    end
    #1;
    if (live && !finished) begin
      compared++;
      if (sel_hi !== exp_hi) begin
        mismatched++;
        $display("FAIL %s R5 high polarity: got %h expected %h", tag, sel_hi, exp_hi);
      end
      compared++;
      if (sel_lo !== ~exp_hi) begin
        mismatched++;
        $display("FAIL %s R6 low polarity: got %h expected %h", tag, sel_lo, ~exp_hi);
      end
    end
  end

  task automatic step(input logic s, input logic inh, input logic [3:0] c);
    @(negedge clk);
    strobe = s; inhibit = inh; code = c;
  endtask

  initial begin
    tag = "R1";
    step(1'b1, 1'b0, 4'd9);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    strobe = 1'b0;
    // R1: idle after reset, then held code 0 shows
    step(1'b0, 1'b0, 4'd7);
    step(1'b0, 1'b0, 4'd12);
    // R2 R4 R10: sweep every code with strobe high
    tag = "R2/R4/R9/R10";
    for (int k = 0; k < 16; k++) step(1'b1, 1'b0, 4'(k));
    for (int k = 15; k >= 0; k -= 3) step(1'b1, 1'b0, 4'(k));
    // R3: strobe low, data wanders, output must stay on last strobed code
    tag = "R3";
    step(1'b1, 1'b0, 4'd5);
    step(1'b0, 1'b0, 4'd10);
    for (int k = 0; k < 16; k++) step(1'b0, 1'b0, 4'(15 - k));
    step(1'b1, 1'b0, 4'd2);
    step(1'b1, 1'b0, 4'd11);
    step(1'b0, 1'b0, 4'd2);
    step(1'b0, 1'b0, 4'd0);
    // R7 R8: inhibit while holding, data moves meanwhile, then release
    tag = "R7/R8";
    step(1'b0, 1'b1, 4'd4);
    step(1'b0, 1'b1, 4'd14);
    step(1'b0, 1'b0, 4'd6);
    step(1'b0, 1'b0, 4'd6);
    // R7: inhibit with strobe high still loads, output stays idle
    tag = "R7";
    step(1'b1, 1'b1, 4'd13);
    step(1'b0, 1'b1, 4'd1);
    tag = "R8";
    step(1'b0, 1'b0, 4'd1);
    step(1'b0, 1'b0, 4'd3);
    // R1: reset in mid-run clears the held code
    tag = "R1";
    step(1'b0, 1'b0, 4'd8);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0, 4'd8);
    step(1'b0, 1'b0, 4'd8);
    step(1'b0, 1'b0, 4'd8);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog R10: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule